// File: doc/BRIEF.md
# Segmented Virtual Address Translator

This block turns a 32-bit virtual address into a physical address. The three top address bits choose a segment. Two of the segment codes are fixed kernel windows. They bypass all lookup and reach physical memory by clearing the top three bits: one window is cacheable and the other is not. Every other address is a mapped reference. It is searched in a 64-entry fully associative translation buffer that holds 4 KB pages. A valid match swaps the 20-bit page number for a 20-bit frame number. A failed search only raises a one-cycle miss flag; any recovery is left to the surrounding logic.

Software keeps the buffer up to date through four small registers: an entry pointer with a probe-failure flag, a free-running replacement counter, and a pair of staging registers that hold one entry's match half and data half. Four operations use these registers: probe, indexed read, indexed write and replacement write. The replacement counter moves down by one on every clock. It is confined to entries 63 down to 8, so entries 0 to 7 can never be chosen by a replacement write. This keeps critical mappings pinned.

A lookup request presented in one cycle gives a registered result in the next cycle.

Top module: `seg_xlate`

## Requirements
- R1: An address whose bits [31:29] are 3'b100 yields, in the cycle after the request, `pa_valid`=1, `pa` = {3'b000, va[28:0]}, `pa_cacheable`=1 and `pa_miss`=0, without consulting the buffer.
- R2: An address whose bits [31:29] are 3'b101 yields `pa` = {3'b000, va[28:0]}, `pa_cacheable`=0 and `pa_miss`=0 one cycle later.
- R3: Any other address is looked up. An entry hits when its valid bit is set and its page number equals va[31:12]. The result is `pa` = {frame, va[11:0]}, and `pa_cacheable` is the inverse of the entry's uncached bit.
- R4: A looked-up address with no valid matching entry gives `pa_miss`=1, `pa`=0 and `pa_cacheable`=0 for that single result cycle. An entry whose page number matches but whose valid bit is clear does not hit.
- R5: When several valid entries match, the lowest-numbered entry supplies the translation.
- R6: Register select 1 reads the replacement counter in bits [13:8], with all other bits zero. It is 63 in reset and decreases by one on every clock. After 8 it returns to 63, so it is never below 8. Writes to select 1 have no effect.
- R7: Register select 0 is the pointer register: pointer in bits [13:8], probe-failure flag in bit 31, all other bits zero. Both fields are writable and the register resets to 0.
- R8: Operation code 1 (probe) compares the match-half page number with every entry, whatever its valid bit. On a match it loads the lowest matching entry number into the pointer and clears bit 31. With no match it sets bit 31 and leaves the pointer unchanged.
- R9: Operation code 2 (indexed read) loads the staging pair from the entry at the pointer. The match half (select 2) reads as page number in [31:12]. The data half (select 3) reads as frame in [31:12], uncached in bit 11 and valid in bit 9. All other bits of both are zero.
- R10: Operation code 3 (indexed write) stores the staging pair into the entry at the pointer.
- R11: Operation code 4 (replacement write) stores the staging pair into the entry named by the counter value in the cycle the code is presented.
- R12: In reset every entry is invalid, both staging registers are zero and `pa_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| va_valid | input | 1 | Translation request strobe |
| va | input | 32 | Virtual address to translate |
| op | input | 3 | Buffer operation: 0 none, 1 probe, 2 indexed read, 3 indexed write, 4 replacement write |
| reg_wr | input | 1 | Register write strobe (ignored when op is 1 or 2) |
| reg_sel | input | 2 | Register select: 0 pointer, 1 counter, 2 match half, 3 data half |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Selected register, combinational |
| pa_valid | output | 1 | Result valid, one cycle after a request |
| pa | output | 32 | Physical address |
| pa_cacheable | output | 1 | Result may be cached |
| pa_miss | output | 1 | Mapped lookup found no valid entry |

## Verification
A corrupted buffer entry or a wrong priority pick shows up at the ports as a wrong frame, a wrong cacheable bit or a false miss. It appears in the result cycle right after the request that touches that entry. A counter that steps wrongly is visible on the next read of select 1, and it makes replacement writes land in the wrong slot. A later indexed read of the slot the bench expects then exposes the error. A faulty probe leaves the pointer or its failure bit wrong, which can be read back at once.

// File: rtl/seg_xlate.sv
`timescale 1ns/1ps
module seg_xlate #(
  parameter int ENTRIES   = 64,
  parameter int LOCKED    = 8,
  parameter int PAGE_BITS = 12
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        va_valid,
  input  logic [31:0] va,
  input  logic [2:0]  op,
  input  logic        reg_wr,
  input  logic [1:0]  reg_sel,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        pa_valid,
  output logic [31:0] pa,
  output logic        pa_cacheable,
  output logic        pa_miss
);
  localparam int IDXW = $clog2(ENTRIES);
  localparam int VPNW = 32 - PAGE_BITS;
  localparam logic [IDXW-1:0] TOP   = IDXW'(ENTRIES - 1);
  localparam logic [IDXW-1:0] FLOOR = IDXW'(LOCKED);
  localparam logic [2:0] OP_PROBE = 3'd1, OP_READ = 3'd2, OP_WIDX = 3'd3, OP_WRND = 3'd4;

  logic [VPNW-1:0] e_vpn [ENTRIES];
  logic [VPNW-1:0] e_pfn [ENTRIES];
  logic [ENTRIES-1:0] e_nc, e_v;

  logic [IDXW-1:0] rnd, idx_ptr;
  logic            idx_fail;
  logic [VPNW-1:0] hi_vpn, lo_pfn;
  logic            lo_nc, lo_v;

  logic [ENTRIES-1:0] lk_match, pr_match;
  logic [IDXW-1:0]    lk_sel, pr_sel;
  logic               lk_hit, pr_hit;
  logic               fixed;

  genvar g;
  generate
    for (g = 0; g < ENTRIES; g++) begin : g_cmp
      assign lk_match[g] = e_v[g] && (e_vpn[g] == va[31:PAGE_BITS]);
      assign pr_match[g] = (e_vpn[g] == hi_vpn);
    end
  endgenerate

  always_comb begin
    lk_hit = 1'b0; lk_sel = '0;
    pr_hit = 1'b0; pr_sel = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (lk_match[i]) begin lk_hit = 1'b1; lk_sel = IDXW'(i); end
      if (pr_match[i]) begin pr_hit = 1'b1; pr_sel = IDXW'(i); end
    end
  end

  assign fixed = (va[31:30] == 2'b10);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pa_valid <= 1'b0;
      pa <= '0;
      pa_cacheable <= 1'b0;
      pa_miss <= 1'b0;
    end else begin
      pa_valid <= va_valid;
      pa_miss  <= va_valid && !fixed && !lk_hit;
      if (fixed) begin
        pa <= {3'b000, va[28:0]};
        pa_cacheable <= !va[29];
      end else if (lk_hit) begin
        pa <= {e_pfn[lk_sel], va[PAGE_BITS-1:0]};
        pa_cacheable <= !e_nc[lk_sel];
      end else begin
        pa <= '0;
        pa_cacheable <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rnd <= TOP;
    else        rnd <= (rnd == FLOOR) ? TOP : rnd - 1'b1;
  end

  logic            ent_we;
  logic [IDXW-1:0] ent_wa;
  assign ent_we = (op == OP_WIDX) || (op == OP_WRND);
  assign ent_wa = (op == OP_WRND) ? rnd : idx_ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) begin
        e_vpn[i] <= '0;
        e_pfn[i] <= '0;
      end
      e_nc <= '0;
      e_v  <= '0;
    end else if (ent_we) begin
      e_vpn[ent_wa] <= hi_vpn;
      e_pfn[ent_wa] <= lo_pfn;
      e_nc[ent_wa]  <= lo_nc;
      e_v[ent_wa]   <= lo_v;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_ptr <= '0; idx_fail <= 1'b0;
      hi_vpn <= '0; lo_pfn <= '0; lo_nc <= 1'b0; lo_v <= 1'b0;
    end else if (op == OP_PROBE) begin
      idx_fail <= !pr_hit;
      if (pr_hit) idx_ptr <= pr_sel;
    end else if (op == OP_READ) begin
      hi_vpn <= e_vpn[idx_ptr];
      lo_pfn <= e_pfn[idx_ptr];
      lo_nc  <= e_nc[idx_ptr];
      lo_v   <= e_v[idx_ptr];
    end else if (reg_wr) begin
      case (reg_sel)
        2'd0: begin idx_ptr <= reg_wdata[8 +: IDXW]; idx_fail <= reg_wdata[31]; end
        2'd2: hi_vpn <= reg_wdata[31:PAGE_BITS];
        2'd3: begin lo_pfn <= reg_wdata[31:PAGE_BITS]; lo_nc <= reg_wdata[11]; lo_v <= reg_wdata[9]; end
        default: ;
      endcase
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_sel)
      2'd0: begin reg_rdata[31] = idx_fail; reg_rdata[8 +: IDXW] = idx_ptr; end
      2'd1: reg_rdata[8 +: IDXW] = rnd;
      2'd2: reg_rdata[31:PAGE_BITS] = hi_vpn;
      default: begin reg_rdata[31:PAGE_BITS] = lo_pfn; reg_rdata[11] = lo_nc; reg_rdata[9] = lo_v; end
    endcase
  end

  p_rnd_floor_r6: assert property (@(posedge clk) disable iff (!rst_n) rnd >= FLOOR);
  p_rnd_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rnd != FLOOR) |=> (rnd == $past(rnd) - 1'b1));
  p_rnd_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rnd == FLOOR) |=> (rnd == TOP));
  p_fixed_seg_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (va_valid && fixed) |=> (pa_valid && !pa_miss && pa[31:29] == 3'b000));
  p_miss_clean_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pa_miss |-> (pa_valid && !pa_cacheable && pa == '0));
  p_probe_hit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_PROBE) |=> (idx_fail || e_vpn[idx_ptr] == $past(hi_vpn)));
endmodule

// File: tb/seg_xlate_bench.sv
`timescale 1ns/1ps
module seg_xlate_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        va_valid = 1'b0;
  logic [31:0] va = '0;
  logic [2:0]  op = '0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_sel = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        pa_valid, pa_cacheable, pa_miss;
  logic [31:0] pa;

  int checks = 0, fails = 0;
  bit done = 1'b0;
  logic [33:0] exp_q[$];
  string       tag_q[$];

  seg_xlate u_seg_xlate (
    .clk(clk), .rst_n(rst_n), .va_valid(va_valid), .va(va), .op(op),
    .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .pa_valid(pa_valid), .pa(pa), .pa_cacheable(pa_cacheable), .pa_miss(pa_miss)
  );

  always #2.5 clk = ~clk;

  task automatic chk(string tag, logic [33:0] act, logic [33:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && pa_valid) begin
      if (exp_q.size() == 0) chk("scoreboard unexpected result", {pa_miss, pa_cacheable, pa}, 34'h0);
      else chk(tag_q.pop_front(), {pa_miss, pa_cacheable, pa}, exp_q.pop_front());
    end
  end

  task automatic lookup(logic [31:0] a, logic [31:0] epa, logic ec, logic em, string tag);
    exp_q.push_back({em, ec, epa});
    tag_q.push_back(tag);
    va = a; va_valid = 1'b1;
    @(posedge clk); #1;
    va_valid = 1'b0;
  endtask

  task automatic reg_write(logic [1:0] s, logic [31:0] d);
    reg_sel = s; reg_wdata = d; reg_wr = 1'b1;
    @(posedge clk); #1;
    reg_wr = 1'b0;
  endtask

  task automatic do_op(logic [2:0] o);
    op = o;
    @(posedge clk); #1;
    op = 3'd0;
  endtask

  task automatic reg_check(logic [1:0] s, logic [31:0] e, string tag);
    reg_sel = s;
    @(negedge clk);
    chk(tag, {2'b00, reg_rdata}, {2'b00, e});
    @(posedge clk); #1;
  endtask

  function automatic logic [31:0] lo_word(logic [19:0] pfn, logic nc, logic v);
    return {pfn, nc, 1'b0, v, 9'b0};
  endfunction

  task automatic stage(logic [19:0] vpn, logic [19:0] pfn, logic nc, logic v);
    reg_write(2'd2, {vpn, 12'h000});
    reg_write(2'd3, lo_word(pfn, nc, v));
  endtask

  task automatic put(int idx, logic [19:0] vpn, logic [19:0] pfn, logic nc, logic v);
    reg_write(2'd0, 32'(idx) << 8);
    stage(vpn, pfn, nc, v);
    do_op(3'd3);
  endtask

  initial begin
    #250000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [5:0] expr, r0, r1;
    repeat (2) @(posedge clk);
    #1;
    chk("R12 pa_valid in reset", {33'h0, pa_valid}, 34'h0);
    reg_check(2'd0, 32'h0, "R7 pointer reset");
    reg_check(2'd1, 32'h0000_3F00, "R6 counter reset");
    reg_check(2'd2, 32'h0, "R12 match half reset");
    reg_check(2'd3, 32'h0, "R12 data half reset");
    rst_n = 1'b1;
    reg_sel = 2'd1;
    expr = 6'd63;
    for (int i = 0; i < 130; i++) begin
      @(negedge clk);
      chk(expr == 6'd63 && i > 0 ? "R6 wrap 8 to 63" : "R6 counter step",
          {2'b00, reg_rdata}, {2'b00, 18'h0, expr, 8'h0});
      expr = (expr == 6'd8) ? 6'd63 : expr - 6'd1;
    end
    @(posedge clk); #1;

    lookup(32'h8012_3456, 32'h0012_3456, 1'b1, 1'b0, "R1 cached kernel");
    lookup(32'h9FFF_FFFC, 32'h1FFF_FFFC, 1'b1, 1'b0, "R1 cached kernel top");
    lookup(32'hA01F_FFF0, 32'h001F_FFF0, 1'b0, 1'b0, "R2 uncached kernel");
    lookup(32'h0040_0ABC, 32'h0, 1'b0, 1'b1, "R12 R4 empty buffer miss");

    put(5, 20'h00400, 20'h00123, 1'b0, 1'b1);
    put(6, 20'h00400, 20'h00777, 1'b0, 1'b1);
    put(7, 20'h7FFFF, 20'h01ABC, 1'b1, 1'b1);
    put(3, 20'h33333, 20'h00044, 1'b0, 1'b0);
    lookup(32'h0040_0ABC, 32'h0012_3ABC, 1'b1, 1'b0, "R3 R10 R5 hit lowest entry");
    lookup(32'h7FFF_F010, 32'h01AB_C010, 1'b0, 1'b0, "R3 uncached entry");
    lookup(32'h3333_3000, 32'h0, 1'b0, 1'b1, "R4 invalid entry miss");
    lookup(32'hC040_0ABC, 32'h0, 1'b0, 1'b1, "R3 R4 upper segment mapped miss");
    lookup(32'h0040_1000, 32'h0, 1'b0, 1'b1, "R4 neighbour page miss");

    reg_write(2'd2, {20'h7FFFF, 12'h000});
    do_op(3'd1);
    reg_check(2'd0, 32'h0000_0700, "R8 probe hit");
    reg_write(2'd2, {20'h33333, 12'h000});
    do_op(3'd1);
    reg_check(2'd0, 32'h0000_0300, "R8 probe ignores valid bit");
    reg_write(2'd2, {20'h55555, 12'h000});
    do_op(3'd1);
    reg_check(2'd0, 32'h8000_0300, "R8 probe miss keeps pointer");
    reg_write(2'd2, {20'h00400, 12'h000});
    do_op(3'd1);
    reg_check(2'd0, 32'h0000_0500, "R8 R5 probe lowest match");

    reg_write(2'd0, 32'hFFFF_FFFF);
    reg_check(2'd0, 32'h8000_3F00, "R7 pointer write mask");

    reg_write(2'd0, 32'h0000_0700);
    do_op(3'd2);
    reg_check(2'd2, 32'h7FFF_F000, "R9 read match half");
    reg_check(2'd3, lo_word(20'h01ABC, 1'b1, 1'b1), "R9 read data half");

    reg_sel = 2'd1; #0.5;
    r0 = reg_rdata[13:8];
    reg_wdata = 32'h0000_0500; reg_wr = 1'b1;
    @(posedge clk); #1;
    reg_wr = 1'b0; #0.5;
    r1 = reg_rdata[13:8];
    chk("R6 counter write ignored", {28'h0, r1}, {28'h0, (r0 == 6'd8) ? 6'd63 : r0 - 6'd1});
    @(posedge clk); #1;

    stage(20'h12345, 20'h0BEEF, 1'b0, 1'b1);
    reg_sel = 2'd1; #0.5;
    r0 = reg_rdata[13:8];
    op = 3'd4;
    @(posedge clk); #1;
    op = 3'd0;
    chk("R11 R6 slot outside locked range", {33'h0, r0 >= 6'd8}, 34'h1);
    lookup(32'h1234_5678, 32'h0BEE_F678, 1'b1, 1'b0, "R11 replacement hit");
    reg_write(2'd2, 32'h0);
    reg_write(2'd0, 32'(r0) << 8);
    do_op(3'd2);
    reg_check(2'd2, 32'h1234_5000, "R11 replacement slot readback");
    lookup(32'h7FFF_F004, 32'h01AB_C004, 1'b0, 1'b0, "R11 locked entry untouched");

    repeat (3) @(posedge clk);
    chk("scoreboard drained", {2'b00, 32'(exp_q.size())}, 34'h0);
    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule